// File: doc/BRIEF.md
# Dual-Issue Dispatch Controller

This block sits between a decoded-instruction queue and a set of execution units. Each cycle it looks at the two oldest queue entries only and decides which of them may leave. An entry may leave when its target unit still holds a free reservation slot, when enough rename registers are free to cover every destination it writes, and when the completion queue has room. For each released instruction it drives the unit select, one rename tag per destination and the completion-queue index allocated to it. It also tells the queue how many entries to pop.

The queue side follows valid/ready rules. `iq_valid[k]` offers entry k, and `iq_pop` acts as the ready. An offered entry stays offered, unchanged, until it is popped. The block never pops an entry that is not valid. A popped count of 1 always removes entry 0. The dispatch lanes have no ready of their own: the units apply back-pressure through their reservation-slot credits. Resources freed by the units, by the rename file and by completion come in as plain inputs.

Top module: `dual_dispatch`

## Requirements
- R1: Only queue entries 0 and 1 are considered. `iq_pop` equals the number of instructions dispatched that cycle (0, 1 or 2). `iq_pop` never counts an entry whose `iq_valid` bit is low.
- R2: Dispatch is in program order. Lane 1 (entry 1) dispatches only in a cycle where lane 0 (entry 0) also dispatches.
- R3: At most one instruction goes to any unit per cycle. If both entries name the same unit, only entry 0 may go.
- R4: Each unit starts with UNIT_SLOTS free reservation slots. Each dispatch to a unit uses one slot. A pulse on `unit_release[u]` returns one slot. An entry whose unit has no free slot is held.
- R5: An instruction with N destinations (0 to MAX_DEST, in `iqX_ndest`) needs N free rename registers, or it is held. Tags are the lowest-numbered free registers in ascending order, with entry 0's destinations taken before entry 1's. Destination k's tag sits at bits [k*TAG_W +: TAG_W] of `dispX_tags`.
- R6: An instruction needs a free completion-queue entry, or it is held. Indices are handed out in circular order, starting at 0 after reset and wrapping from CQ_DEPTH-1 to 0. Entry 0 takes the earlier index. `cq_retire` frees that many of the oldest entries.
- R7: Slots, rename registers and completion entries released in a cycle become usable from the next cycle, not in the same cycle.
- R8: After reset, every unit slot and every rename register is free and the completion queue is empty. The unit, tag and index fields of a lane that does not dispatch read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iq_valid | input | 2 | Bit k: queue entry k holds an instruction |
| iq0_unit | input | UNIT_W | Target unit of entry 0 |
| iq0_ndest | input | DEST_W | Destination count of entry 0 |
| iq1_unit | input | UNIT_W | Target unit of entry 1 |
| iq1_ndest | input | DEST_W | Destination count of entry 1 |
| iq_pop | output | 2 | Entries to pop this cycle |
| disp_valid | output | 2 | Bit k: lane k dispatches |
| disp0_unit | output | UNIT_W | Unit select, lane 0 |
| disp0_tags | output | MAX_DEST*TAG_W | Rename tags, lane 0 |
| disp0_cq | output | CQ_W | Completion index, lane 0 |
| disp1_unit | output | UNIT_W | Unit select, lane 1 |
| disp1_tags | output | MAX_DEST*TAG_W | Rename tags, lane 1 |
| disp1_cq | output | CQ_W | Completion index, lane 1 |
| unit_release | input | NUM_UNITS | Bit u: unit u frees one reservation slot |
| rename_release | input | RENAME_REGS | Bit r: rename register r becomes free |
| cq_retire | input | 2 | Oldest completion entries retired this cycle |

## Verification
The bench uses the default parameters: four units with two slots each, six rename registers, a six-entry completion queue and up to two destinations per instruction. With only six rename registers, two destinations per instruction quickly run the pool dry, so stalls on rename shortage happen often. The non-power-of-two completion depth makes the index wrap from 5 to 0 frequent. Two slots per unit separate the same-unit rule from the slot-credit rule, because a unit can still have a free slot when entry 1 is held back for sharing it with entry 0.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [1:0] {
    POP_NONE = 2'd0,
    POP_ONE  = 2'd1,
    POP_TWO  = 2'd2
  } pop_e;

  function automatic int safe_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dsp_unit_credit.sv
module dsp_unit_credit #(
  parameter int SLOTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic release_i,
  output logic has_slot
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] free_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= CNT_W'(SLOTS);
    end else if (take && !release_i) begin
      free_q <= free_q - 1'b1;
    end else if (!take && release_i) begin
      free_q <= free_q + 1'b1;
    end
  end

  assign has_slot = (free_q != '0);

  AST_UNIT_NO_OVERTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> free_q != '0); // R4
  AST_UNIT_RELEASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !take) |-> int'(free_q) < SLOTS); // R4
  AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_q) <= SLOTS); // R4

endmodule

// File: rtl/dsp_rename_pool.sv
module dsp_rename_pool #(
  parameter int REGS = 6,
  parameter int MAXD = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take0,
  input  logic [$clog2(MAXD+1)-1:0] nd0,
  input  logic                     take1,
  input  logic [$clog2(MAXD+1)-1:0] nd1,
  input  logic [REGS-1:0]          release_mask,
  output logic [MAXD*$clog2(REGS)-1:0] tags0,
  output logic [MAXD*$clog2(REGS)-1:0] tags1,
  output logic [$clog2(REGS+1)-1:0] free_cnt
);
  localparam int TW    = $clog2(REGS);
  localparam int PICKS = 2 * MAXD;

  logic [REGS-1:0] free_q;
  logic [REGS-1:0] alloc;
  logic [TW-1:0]   pick [PICKS];

  // Ordered list of the lowest free register numbers.
  always_comb begin
    int n;
    n = 0;
    for (int k = 0; k < PICKS; k++) pick[k] = '0;
    for (int i = 0; i < REGS; i++) begin
      if (free_q[i] && n < PICKS) begin
        pick[n] = TW'(i);
        n++;
      end
    end
  end

  // Lane 0 consumes from the front of the list, lane 1 right after it.
  always_comb begin
    alloc = '0;
    tags0 = '0;
    tags1 = '0;
    for (int k = 0; k < MAXD; k++) begin
      if (take0 && k < int'(nd0)) begin
        tags0[k*TW +: TW] = pick[k];
        alloc[pick[k]]    = 1'b1;
      end
      if (take1 && k < int'(nd1) && (int'(nd0) + k) < PICKS) begin
        tags1[k*TW +: TW]         = pick[int'(nd0) + k];
        alloc[pick[int'(nd0) + k]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= (free_q & ~alloc) | release_mask;
  end

  assign free_cnt = ($clog2(REGS+1))'($countones(free_q));

  AST_RENAME_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (release_mask & free_q) == '0); // R5
  AST_RENAME_ENOUGH0: assert property (@(posedge clk) disable iff (!rst_n)
    take0 |-> $countones(free_q) >= int'(nd0)); // R5
  AST_RENAME_ENOUGH01: assert property (@(posedge clk) disable iff (!rst_n)
    (take0 && take1) |-> $countones(free_q) >= int'(nd0) + int'(nd1)); // R5

endmodule

// File: rtl/dsp_cq_alloc.sv
module dsp_cq_alloc #(
  parameter int DEPTH = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 n_alloc,
  input  logic [1:0]                 n_retire,
  output logic [$clog2(DEPTH)-1:0]   idx0,
  output logic [$clog2(DEPTH)-1:0]   idx1,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt
);
  localparam int IW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic [IW-1:0] tail_q;
  logic [FW-1:0] used_q;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] p, input int inc);
    int t;
    t = int'(p) + inc;
    if (t >= DEPTH) t = t - DEPTH;
    return IW'(t);
  endfunction

  assign idx0     = tail_q;
  assign idx1     = wrap_add(tail_q, 1);
  assign free_cnt = FW'(DEPTH) - used_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
      used_q <= '0;
    end else begin
      tail_q <= wrap_add(tail_q, int'(n_alloc));
      used_q <= used_q + FW'(n_alloc) - FW'(n_retire);
    end
  end

  AST_CQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n_alloc) <= DEPTH - int'(used_q)); // R6
  AST_CQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n_retire) <= int'(used_q)); // R6
  AST_CQ_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tail_q) < DEPTH); // R6

endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch
  import dsp_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int UNIT_SLOTS  = 2,
  parameter int RENAME_REGS = 6,
  parameter int CQ_DEPTH    = 6,
  parameter int MAX_DEST    = 2,
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int DEST_W = $clog2(MAX_DEST + 1),
  localparam int TAG_W  = $clog2(RENAME_REGS),
  localparam int CQ_W   = $clog2(CQ_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                iq_valid,
  input  logic [UNIT_W-1:0]         iq0_unit,
  input  logic [DEST_W-1:0]         iq0_ndest,
  input  logic [UNIT_W-1:0]         iq1_unit,
  input  logic [DEST_W-1:0]         iq1_ndest,
  output logic [1:0]                iq_pop,
  output logic [1:0]                disp_valid,
  output logic [UNIT_W-1:0]         disp0_unit,
  output logic [MAX_DEST*TAG_W-1:0] disp0_tags,
  output logic [CQ_W-1:0]           disp0_cq,
  output logic [UNIT_W-1:0]         disp1_unit,
  output logic [MAX_DEST*TAG_W-1:0] disp1_tags,
  output logic [CQ_W-1:0]           disp1_cq,
  input  logic [NUM_UNITS-1:0]      unit_release,
  input  logic [RENAME_REGS-1:0]    rename_release,
  input  logic [1:0]                cq_retire
);
  localparam int RF_W = $clog2(RENAME_REGS + 1);
  localparam int CF_W = $clog2(CQ_DEPTH + 1);

  logic [NUM_UNITS-1:0] unit_has_slot;
  logic [NUM_UNITS-1:0] unit_take;
  logic [RF_W-1:0]      rn_free;
  logic [CF_W-1:0]      cq_free;
  logic [CQ_W-1:0]      cq_idx0, cq_idx1;
  logic                 go0, go1;
  pop_e                 pop;

  // Per-unit reservation credits.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    dsp_unit_credit #(.SLOTS(UNIT_SLOTS)) u_credit (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (unit_take[u]),
      .release_i(unit_release[u]),
      .has_slot (unit_has_slot[u])
    );
  end

  // Lane qualification, oldest first.
  always_comb begin
    go0 = iq_valid[0]
       && int'(iq0_unit) < NUM_UNITS
       && unit_has_slot[iq0_unit]
       && int'(iq0_ndest) <= MAX_DEST
       && int'(rn_free) >= int'(iq0_ndest)
       && int'(cq_free) >= 1;
    go1 = go0
       && iq_valid[1]
       && int'(iq1_unit) < NUM_UNITS
       && iq1_unit != iq0_unit
       && unit_has_slot[iq1_unit]
       && int'(iq1_ndest) <= MAX_DEST
       && int'(rn_free) >= int'(iq0_ndest) + int'(iq1_ndest)
       && int'(cq_free) >= 2;
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      unit_take[u] = (go0 && iq0_unit == UNIT_W'(u)) || (go1 && iq1_unit == UNIT_W'(u));
    end
  end

  always_comb begin
    if (go1)      pop = POP_TWO;
    else if (go0) pop = POP_ONE;
    else          pop = POP_NONE;
  end

  dsp_rename_pool #(.REGS(RENAME_REGS), .MAXD(MAX_DEST)) u_rename (
    .clk         (clk),
    .rst_n       (rst_n),
    .take0       (go0),
    .nd0         (iq0_ndest),
    .take1       (go1),
    .nd1         (iq1_ndest),
    .release_mask(rename_release),
    .tags0       (disp0_tags),
    .tags1       (disp1_tags),
    .free_cnt    (rn_free)
  );

  dsp_cq_alloc #(.DEPTH(CQ_DEPTH)) u_cq (
    .clk     (clk),
    .rst_n   (rst_n),
    .n_alloc (2'(pop)),
    .n_retire(cq_retire),
    .idx0    (cq_idx0),
    .idx1    (cq_idx1),
    .free_cnt(cq_free)
  );

  assign iq_pop     = 2'(pop);
  assign disp_valid = {go1, go0};
  assign disp0_unit = go0 ? iq0_unit : '0;
  assign disp1_unit = go1 ? iq1_unit : '0;
  assign disp0_cq   = go0 ? cq_idx0 : '0;
  assign disp1_cq   = go1 ? cq_idx1 : '0;

  AST_POP_ONLY_VALID0: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[0] |-> iq_valid[0]); // R1
  AST_POP_ONLY_VALID1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[1] |-> iq_valid[1]); // R1
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[1] |-> disp_valid[0]); // R2
  AST_UNIT_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid == 2'b11) |-> disp0_unit != disp1_unit); // R3
  AST_CQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid == 2'b11) |-> disp0_cq != disp1_cq); // R6

endmodule

// File: tb/dual_dispatch_tb.sv
module dual_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 4;
  localparam int SL = 2;
  localparam int RR = 6;
  localparam int CQD = 6;
  localparam int MD = 2;
  localparam int UW = 2;
  localparam int DW = 2;
  localparam int TW = 3;
  localparam int CW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] iq_valid = '0;
  logic [UW-1:0] iq0_unit = '0, iq1_unit = '0;
  logic [DW-1:0] iq0_ndest = '0, iq1_ndest = '0;
  logic [1:0] iq_pop, disp_valid;
  logic [UW-1:0] disp0_unit, disp1_unit;
  logic [MD*TW-1:0] disp0_tags, disp1_tags;
  logic [CW-1:0] disp0_cq, disp1_cq;
  logic [NU-1:0] unit_release = '0;
  logic [RR-1:0] rename_release = '0;
  logic [1:0] cq_retire = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dispatch #(.NUM_UNITS(NU), .UNIT_SLOTS(SL), .RENAME_REGS(RR),
                  .CQ_DEPTH(CQD), .MAX_DEST(MD)) u_dut (
    .clk(clk), .rst_n(rst_n), .iq_valid(iq_valid),
    .iq0_unit(iq0_unit), .iq0_ndest(iq0_ndest),
    .iq1_unit(iq1_unit), .iq1_ndest(iq1_ndest),
    .iq_pop(iq_pop), .disp_valid(disp_valid),
    .disp0_unit(disp0_unit), .disp0_tags(disp0_tags), .disp0_cq(disp0_cq),
    .disp1_unit(disp1_unit), .disp1_tags(disp1_tags), .disp1_cq(disp1_cq),
    .unit_release(unit_release), .rename_release(rename_release),
    .cq_retire(cq_retire)
  );

  int errors = 0;
  int checks = 0;

  // Bench-side resource model built from the requirements.
  int m_cred [NU];
  logic [RR-1:0] m_free;
  int m_cq_used, m_cq_tail;
  int e_pop, e_u0, e_u1, e_cq0, e_cq1;
  logic e_go0, e_go1;
  logic [MD*TW-1:0] e_t0, e_t1;
  logic [RR-1:0] e_alloc;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int count_free(input logic [RR-1:0] f);
    int c = 0;
    for (int i = 0; i < RR; i++) if (f[i]) c++;
    return c;
  endfunction

  task automatic model_reset();
    for (int u = 0; u < NU; u++) m_cred[u] = SL;
    m_free = '1;
    m_cq_used = 0;
    m_cq_tail = 0;
  endtask

  task automatic model_eval();
    int list [2*MD];
    int n, nf, cqf;
    n = 0;
    for (int k = 0; k < 2*MD; k++) list[k] = 0;
    for (int i = 0; i < RR; i++) if (m_free[i] && n < 2*MD) begin list[n] = i; n++; end
    nf  = count_free(m_free);
    cqf = CQD - m_cq_used;
    e_go0 = iq_valid[0] && m_cred[iq0_unit] > 0 && nf >= int'(iq0_ndest) && cqf >= 1;
    e_go1 = e_go0 && iq_valid[1] && iq1_unit != iq0_unit && m_cred[iq1_unit] > 0
            && nf >= int'(iq0_ndest) + int'(iq1_ndest) && cqf >= 2;
    e_pop = int'(e_go0) + int'(e_go1);
    e_u0  = e_go0 ? int'(iq0_unit) : 0;
    e_u1  = e_go1 ? int'(iq1_unit) : 0;
    e_cq0 = e_go0 ? m_cq_tail : 0;
    e_cq1 = e_go1 ? ((m_cq_tail + 1) % CQD) : 0;
    e_t0 = '0; e_t1 = '0; e_alloc = '0;
    for (int k = 0; k < MD; k++) begin
      if (e_go0 && k < int'(iq0_ndest)) begin
        e_t0[k*TW +: TW] = TW'(list[k]); e_alloc[list[k]] = 1'b1;
      end
      if (e_go1 && k < int'(iq1_ndest)) begin
        e_t1[k*TW +: TW] = TW'(list[int'(iq0_ndest)+k]); e_alloc[list[int'(iq0_ndest)+k]] = 1'b1;
      end
    end
  endtask

  task automatic model_commit();
    if (e_go0) m_cred[iq0_unit]--;
    if (e_go1) m_cred[iq1_unit]--;
    for (int u = 0; u < NU; u++) if (unit_release[u]) m_cred[u]++;
    m_free = (m_free & ~e_alloc) | rename_release;
    m_cq_used = m_cq_used + e_pop - int'(cq_retire);
    m_cq_tail = (m_cq_tail + e_pop) % CQD;
  endtask

  task automatic compare_all();
    check("R1", "iq_pop", int'(iq_pop), e_pop);
    check("R2", "disp_valid", int'(disp_valid), int'({e_go1, e_go0}));
    check("R3", "disp0_unit", int'(disp0_unit), e_u0);
    check("R3", "disp1_unit", int'(disp1_unit), e_u1);
    check("R5", "disp0_tags", int'(disp0_tags), int'(e_t0));
    check("R5", "disp1_tags", int'(disp1_tags), int'(e_t1));
    check("R6", "disp0_cq", int'(disp0_cq), e_cq0);
    check("R6", "disp1_cq", int'(disp1_cq), e_cq1);
  endtask

  // One cycle: drive at negedge, compare after settle, commit at posedge.
  task automatic cycle(input logic [1:0] v, input int u0, input int d0,
                       input int u1, input int d1, input logic rand_rel);
    @(negedge clk);
    iq_valid = v;
    iq0_unit = UW'(u0); iq0_ndest = DW'(d0);
    iq1_unit = UW'(u1); iq1_ndest = DW'(d1);
    unit_release = '0; rename_release = '0; cq_retire = '0;
    if (rand_rel) begin
      for (int u = 0; u < NU; u++)
        if (m_cred[u] < SL && ($urandom % 3) == 0) unit_release[u] = 1'b1;
      for (int r = 0; r < RR; r++)
        if (!m_free[r] && ($urandom % 4) == 0) rename_release[r] = 1'b1;
      if (m_cq_used > 0) begin
        int rt;
        rt = int'($urandom % 3);
        if (rt > m_cq_used) rt = m_cq_used;
        cq_retire = 2'(rt);
      end
    end
    #1;
    model_eval();
    compare_all();
    @(posedge clk);
    model_commit();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R8: idle after reset, nothing offered, nothing dispatched.
    #1;
    check("R8", "reset disp_valid", int'(disp_valid), 0);
    check("R8", "reset iq_pop", int'(iq_pop), 0);
    check("R8", "reset disp0_tags", int'(disp0_tags), 0);

    // R8/R5/R6: first dual dispatch takes tags from 0 and cq indices 0,1.
    cycle(2'b11, 0, 1, 1, 2, 1'b0);
    check("R8", "first tags lane0", int'(disp0_tags), 0);
    check("R5", "first tags lane1", int'(disp1_tags), 1 | (2 << TW));
    check("R6", "first cq lane1", int'(disp1_cq), 1);

    // R3: same unit, only entry 0 goes.
    cycle(2'b11, 2, 0, 2, 0, 1'b0);
    check("R3", "same unit pop", int'(iq_pop), 1);

    // R2: entry 0 invalid holds entry 1.
    cycle(2'b10, 0, 0, 3, 0, 1'b0);
    check("R2", "hold behind empty", int'(disp_valid), 0);

    // R4: unit 0 has one slot left, drain it, then held.
    cycle(2'b01, 0, 0, 0, 0, 1'b0);
    cycle(2'b01, 0, 0, 0, 0, 1'b0);
    check("R4", "unit0 no slot", int'(disp_valid), 0);

    // R7: release unit 0 in this cycle, still held this cycle, goes next.
    @(negedge clk);
    iq_valid = 2'b01; iq0_unit = '0; iq0_ndest = '0;
    unit_release = 4'b0001; rename_release = '0; cq_retire = '0;
    #1;
    check("R7", "release same cycle", int'(disp_valid), 0);
    @(posedge clk);
    m_cred[0]++;
    cycle(2'b01, 0, 0, 0, 0, 1'b0);
    check("R7", "release next cycle", int'(disp_valid), 1);

    // R5: rename pool has 3 free; needs 2+2 -> only lane 0.
    cycle(2'b11, 1, 2, 3, 2, 1'b0);
    check("R5", "rename short lane1", int'(iq_pop), 1);

    // R6: completion queue fills up, then stalls.
    for (int i = 0; i < 4; i++) cycle(2'b01, 3, 0, 0, 0, 1'b1);

    // Constrained random mix.
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] v;
      int u0, u1;
      v  = 2'($urandom);
      u0 = int'($urandom % NU);
      u1 = (($urandom % 4) == 0) ? u0 : int'($urandom % NU);
      cycle(v, u0, int'($urandom % (MD+1)), u1, int'($urandom % (MD+1)), 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule